// File: doc/BRIEF.md
# Atomic Bit Set/Clear Register Bank

This block holds a bank of 32-bit control registers that several bus masters share. A master can write a whole word at a plain address. It can also write through one of two alias views of the same protected window. In an alias view the write data is a bit number, and only that one bit of the target register is set or cleared. Because the update happens in one bus access, masters that own different bits of a register never need a read-modify-write sequence and cannot overwrite each other's changes.

The address is 17 bits wide and addresses bytes. Bit 16 chooses the region. When bit 16 is 0 the access goes to the protected window. When bit 16 is 1 it goes to a small open region that has no alias views. Bits 15:14 hold the alias operation: 00 is a plain access, 11 sets a bit, 10 clears a bit and 01 is reserved. Bits 13:2 hold the word index and bits 1:0 must be zero. Writes to the protected window need the secure qualifier. Reads of any mapped register are allowed at every privilege level.

The request side has no back-pressure. A request is taken on every cycle in which `req_valid` is high. Exactly one cycle later the block returns a response with an error flag and, for reads, the data. The requester cannot stall the response.

Top module: `atbank_top`

## Requirements
- R1: After reset every register reads zero. A secure plain write (bits 15:14 = 00) to a window register replaces all 32 bits of that register.
- R2: A secure write with address bits 15:14 = 11 sets bit `wdata[4:0]` of the addressed window register and leaves the other 31 bits unchanged.
- R3: A secure write with address bits 15:14 = 10 clears bit `wdata[4:0]` of the addressed window register and leaves the other 31 bits unchanged.
- R4: An alias write whose data value is 32 or more returns an error and changes no register.
- R5: A window register named in parameter `NOATOMIC_MASK` (default: registers 2 and 5) accepts plain writes. An alias write to such a register returns an error and does not modify it.
- R6: A window write without `req_secure` returns an error and leaves the register unchanged. Writes to the open region succeed whatever the value of `req_secure`.
- R7: Reads succeed with or without `req_secure`. A read through an alias address (bits 15:14 = 11 or 10) returns the current value of the target register.
- R8: A window write with address bits 15:14 = 01 returns an error and changes no register.
- R9: In the open region (bit 16 = 1) an access with bits 15:14 other than 00 returns an error, and a write of this kind changes nothing.
- R10: An access to a word index outside the region, or with address bits 1:0 not zero, returns an error, and a read of this kind returns zero data.
- R11: `rsp_valid` is high exactly in the cycle after each accepted request. `rsp_err` is high only together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present. It is accepted in the same cycle. |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address: region bit, alias operation bits, word index |
| req_wdata | input | 32 | Write value, or the bit number for an alias write |
| req_secure | input | 1 | Secure-privilege qualifier |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_err | output | 1 | The request was rejected |
| rsp_rdata | output | 32 | Read data. It is zero for writes and for rejected reads. |

## Verification
On every cycle the assertions check three things. First, the one-cycle response timing. Second, that rejected non-secure window writes and out-of-range alias writes raise the error flag. Third, inside each register cell, that a set or clear changes exactly the named bit and that a register with no write enable holds its value.

Only the bench scenarios can show the rest, because it depends on which register an address reaches and on what is read back later. This covers the alias read view, the masking of the non-atomic registers, the rejection of the reserved pattern and of open-region alias writes, and the zero data on unmapped reads.

// File: rtl/atbank_pkg.sv
package atbank_pkg;

  typedef enum logic [1:0] {
    OP_PLAIN = 2'b00,
    OP_RSVD  = 2'b01,
    OP_CLR   = 2'b10,
    OP_SET   = 2'b11
  } alias_op_e;

  typedef enum logic [1:0] {
    RG_WIN  = 2'b00,
    RG_OUT  = 2'b01,
    RG_NONE = 2'b10
  } region_e;

  typedef struct packed {
    region_e   region;
    alias_op_e op;
    logic      misaligned;
  } dec_t;

endpackage

// File: rtl/atbank_decode.sv
module atbank_decode
  import atbank_pkg::*;
#(
  parameter int NUM_WIN = 16,
  parameter int NUM_OUT = 4,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int OIDX_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic [16:0]       addr,
  output dec_t              dec,
  output logic [IDX_W-1:0]  win_idx,
  output logic [OIDX_W-1:0] out_idx
);

  localparam logic [11:0] WIN_LIM = 12'(NUM_WIN);
  localparam logic [11:0] OUT_LIM = 12'(NUM_OUT);

  logic [11:0] word;

  always_comb begin
    word           = addr[13:2];
    dec.op         = alias_op_e'(addr[15:14]);
    dec.misaligned = |addr[1:0];
    if (addr[16]) dec.region = (word < OUT_LIM) ? RG_OUT : RG_NONE;
    else          dec.region = (word < WIN_LIM) ? RG_WIN : RG_NONE;
    win_idx = word[IDX_W-1:0];
    out_idx = word[OIDX_W-1:0];
  end

endmodule

// File: rtl/atbank_policy.sv
module atbank_policy
  import atbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  logic        write,
  input  logic        secure,
  input  logic [31:0] wdata,
  input  dec_t        dec,
  input  logic        atomic_ok,
  output logic        err,
  output logic        do_full,
  output logic        do_set,
  output logic        do_clr,
  output logic        to_win
);

  logic big_idx;

  always_comb begin
    big_idx = |wdata[31:5];
    err     = 1'b0;
    do_full = 1'b0;
    do_set  = 1'b0;
    do_clr  = 1'b0;
    to_win  = (dec.region == RG_WIN);
    if (valid) begin
      if (dec.region == RG_NONE || dec.misaligned) begin
        err = 1'b1;
      end else if (!write) begin
        err = (dec.region == RG_OUT) && (dec.op != OP_PLAIN);
      end else if (dec.region == RG_OUT) begin
        if (dec.op != OP_PLAIN) err = 1'b1;
        else                    do_full = 1'b1;
      end else begin
        if (!secure) err = 1'b1;
        else begin
          unique case (dec.op)
            OP_PLAIN: do_full = 1'b1;
            OP_RSVD:  err = 1'b1;
            default: begin
              if (big_idx || !atomic_ok) err = 1'b1;
              else if (dec.op == OP_SET) do_set = 1'b1;
              else do_clr = 1'b1;
            end
          endcase
        end
      end
    end
  end

  // R5: an alias update never reaches a register that has no atomic support
  a_r5_mask_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (do_set || do_clr) |-> (atomic_ok && to_win));
  // R11: a rejected request performs no update
  a_r11_err_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !(do_full || do_set || do_clr));

endmodule

// File: rtl/atbank_cell.sv
module atbank_cell #(
  parameter int W = 32,
  localparam int BIT_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_full,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [BIT_W-1:0] bitidx,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     q
);

  logic [W-1:0] onehot;

  always_comb onehot = {{(W-1){1'b0}}, 1'b1} << bitidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (wr_full) q <= wdata;
    else if (wr_set)  q <= q | onehot;
    else if (wr_clr)  q <= q & ~onehot;
  end

  // R2: a set turns on the named bit and leaves the others alone
  a_r2_set_single: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && !wr_full) |=> (q[$past(bitidx)] && ((q ^ $past(q)) & ~($past(onehot))) == '0));
  // R3: a clear turns off the named bit and leaves the others alone
  a_r3_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !wr_full && !wr_set) |=> (!q[$past(bitidx)] && ((q ^ $past(q)) & ~($past(onehot))) == '0));
  // R1: a register without an enable holds its value
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_full || wr_set || wr_clr) |=> $stable(q));

endmodule

// File: rtl/atbank_top.sv
module atbank_top
  import atbank_pkg::*;
#(
  parameter int               NUM_WIN       = 16,
  parameter int               NUM_OUT       = 4,
  parameter logic [NUM_WIN-1:0] NOATOMIC_MASK = 16'h0024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [16:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic        req_secure,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata
);

  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int OIDX_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

  dec_t              dec;
  logic [IDX_W-1:0]  win_idx;
  logic [OIDX_W-1:0] out_idx;
  logic              atomic_ok, err, do_full, do_set, do_clr, to_win;
  logic [31:0]       win_q [NUM_WIN];
  logic [31:0]       out_q [NUM_OUT];
  logic [31:0]       rd_val;

  atbank_decode #(.NUM_WIN(NUM_WIN), .NUM_OUT(NUM_OUT)) u_dec (
    .addr(req_addr), .dec(dec), .win_idx(win_idx), .out_idx(out_idx)
  );

  always_comb atomic_ok = !NOATOMIC_MASK[win_idx];

  atbank_policy u_pol (
    .clk(clk), .rst_n(rst_n), .valid(req_valid), .write(req_write),
    .secure(req_secure), .wdata(req_wdata), .dec(dec), .atomic_ok(atomic_ok),
    .err(err), .do_full(do_full), .do_set(do_set), .do_clr(do_clr), .to_win(to_win)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic hit;
    always_comb hit = to_win && (win_idx == IDX_W'(i));
    atbank_cell #(.W(32)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .wr_full(hit && do_full), .wr_set(hit && do_set), .wr_clr(hit && do_clr),
      .bitidx(req_wdata[4:0]), .wdata(req_wdata), .q(win_q[i])
    );
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    logic hit;
    always_comb hit = !to_win && (out_idx == OIDX_W'(j));
    atbank_cell #(.W(32)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .wr_full(hit && do_full), .wr_set(1'b0), .wr_clr(1'b0),
      .bitidx(req_wdata[4:0]), .wdata(req_wdata), .q(out_q[j])
    );
  end

  always_comb begin
    rd_val = '0;
    if (req_valid && !req_write && !err) begin
      if (dec.region == RG_WIN)      rd_val = win_q[win_idx];
      else if (dec.region == RG_OUT) rd_val = out_q[out_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= err;
      rsp_rdata <= rd_val;
    end
  end

  // R11: a response follows each request by one cycle
  a_r11_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r11_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  // R6: a non-secure write to the window is rejected
  a_r6_nonsecure: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_addr[16] && !req_secure) |=> rsp_err);
  // R4: an alias write with bit number 32 or more is rejected
  a_r4_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[15] && (|req_wdata[31:5])) |=> rsp_err);

endmodule

// File: tb/tb_atbank_top.sv
module tb_atbank_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_secure = 1'b0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  int total = 0;
  int bad = 0;
  logic        got_err;
  logic [31:0] got_data;

  always #5 clk = ~clk;

  atbank_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_secure(req_secure),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [16:0] adr(input logic outer, input logic [1:0] op, input int idx);
    return {outer, op, 12'(idx), 2'b00};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [16:0] a, input logic [31:0] d, input logic sec);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_secure = sec;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check("R11 rsp_valid", 32'(rsp_valid), 32'd1);
    got_err = rsp_err;
    got_data = rsp_rdata;
  endtask

  task automatic rd_expect(input string req, input logic [16:0] a, input logic [31:0] exp, input logic sec);
    access(1'b0, a, 32'd0, sec);
    check({req, " read err"}, 32'(got_err), 32'd0);
    check({req, " read data"}, got_data, exp);
  endtask

  task automatic t_reset;
    check("R11 idle valid", 32'(rsp_valid), 32'd0);
    for (int i = 0; i < 16; i++) rd_expect("R1 reset", adr(0, 2'b00, i), 32'd0, 1'b1);
  endtask

  task automatic t_plain;
    access(1, adr(0, 2'b00, 3), 32'hDEAD_BEEF, 1);
    check("R1 write err", 32'(got_err), 0);
    rd_expect("R1 replace", adr(0, 2'b00, 3), 32'hDEAD_BEEF, 1);
    rd_expect("R7 nonsecure read", adr(0, 2'b00, 3), 32'hDEAD_BEEF, 0);
  endtask

  task automatic t_set;
    access(1, adr(0, 2'b00, 4), 32'h0000_1000, 1);
    access(1, adr(0, 2'b11, 4), 32'd0, 1);
    check("R2 set err", 32'(got_err), 0);
    access(1, adr(0, 2'b11, 4), 32'd31, 1);
    rd_expect("R2 set bits", adr(0, 2'b00, 4), 32'h8000_1001, 1);
    rd_expect("R7 alias read set view", adr(0, 2'b11, 4), 32'h8000_1001, 0);
  endtask

  task automatic t_clr;
    access(1, adr(0, 2'b10, 4), 32'd12, 1);
    check("R3 clr err", 32'(got_err), 0);
    access(1, adr(0, 2'b10, 4), 32'd7, 1);
    rd_expect("R3 clear bit", adr(0, 2'b10, 4), 32'h8000_0001, 1);
  endtask

  task automatic t_bigidx;
    access(1, adr(0, 2'b11, 4), 32'd32, 1);
    check("R4 idx32 err", 32'(got_err), 1);
    access(1, adr(0, 2'b10, 4), 32'hFFFF_FFFF, 1);
    check("R4 idx max err", 32'(got_err), 1);
    rd_expect("R4 unchanged", adr(0, 2'b00, 4), 32'h8000_0001, 1);
  endtask

  task automatic t_noatomic;
    access(1, adr(0, 2'b00, 2), 32'h0000_00F0, 1);
    check("R5 plain ok", 32'(got_err), 0);
    access(1, adr(0, 2'b11, 2), 32'd0, 1);
    check("R5 set err", 32'(got_err), 1);
    access(1, adr(0, 2'b10, 5), 32'd4, 1);
    check("R5 clr err", 32'(got_err), 1);
    rd_expect("R5 unchanged", adr(0, 2'b00, 2), 32'h0000_00F0, 1);
    rd_expect("R5 reg5 zero", adr(0, 2'b00, 5), 32'd0, 1);
  endtask

  task automatic t_privilege;
    access(1, adr(0, 2'b00, 3), 32'h1234_5678, 0);
    check("R6 plain nonsecure err", 32'(got_err), 1);
    access(1, adr(0, 2'b11, 3), 32'd0, 0);
    check("R6 alias nonsecure err", 32'(got_err), 1);
    rd_expect("R6 unchanged", adr(0, 2'b00, 3), 32'hDEAD_BEEF, 0);
    access(1, adr(1, 2'b00, 1), 32'hA5A5_0F0F, 0);
    check("R6 open region ok", 32'(got_err), 0);
    rd_expect("R6 open region data", adr(1, 2'b00, 1), 32'hA5A5_0F0F, 0);
  endtask

  task automatic t_reserved;
    access(1, adr(0, 2'b01, 3), 32'h0, 1);
    check("R8 reserved err", 32'(got_err), 1);
    rd_expect("R8 unchanged", adr(0, 2'b00, 3), 32'hDEAD_BEEF, 1);
  endtask

  task automatic t_open_alias;
    access(1, adr(1, 2'b11, 1), 32'd1, 1);
    check("R9 open set err", 32'(got_err), 1);
    access(1, adr(1, 2'b10, 1), 32'd0, 1);
    check("R9 open clr err", 32'(got_err), 1);
    access(0, adr(1, 2'b11, 1), 32'd0, 1);
    check("R9 open alias read err", 32'(got_err), 1);
    rd_expect("R9 unchanged", adr(1, 2'b00, 1), 32'hA5A5_0F0F, 1);
  endtask

  task automatic t_unmapped;
    access(0, adr(0, 2'b00, 16), 32'd0, 1);
    check("R10 unmapped err", 32'(got_err), 1);
    check("R10 unmapped data", got_data, 0);
    access(0, adr(1, 2'b00, 4), 32'd0, 1);
    check("R10 open unmapped err", 32'(got_err), 1);
    access(0, adr(0, 2'b00, 3) | 17'd2, 32'd0, 1);
    check("R10 misaligned err", 32'(got_err), 1);
    check("R10 misaligned data", got_data, 0);
    access(1, adr(0, 2'b00, 3) | 17'd1, 32'h0, 1);
    check("R10 misaligned write err", 32'(got_err), 1);
    rd_expect("R10 unchanged", adr(0, 2'b00, 3), 32'hDEAD_BEEF, 1);
  endtask

  task automatic t_timing;
    @(negedge clk);
    @(posedge clk); #1;
    check("R11 no rsp when idle", 32'(rsp_valid), 0);
    check("R11 no err when idle", 32'(rsp_err), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_plain();
    t_set();
    t_clr();
    t_bigidx();
    t_noatomic();
    t_privilege();
    t_reserved();
    t_open_alias();
    t_unmapped();
    t_timing();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule